// File: doc/BRIEF.md
# Serial-Commanded Six-Channel Gate Enable Controller

This block is the digital core of a six-channel low-side driver. A host writes channel on/off commands through a serial peripheral port that works in clock-idle-low, sample-on-leading-edge form. Bits enter on SI at each rising SCK edge, most significant first, into a shift register. When chip select (`cs_n`, active low) returns high after exactly 8 or 16 clock edges, the last six bits received are copied into a command latch. Any other frame is thrown away and the latch keeps its value. In the same frame, the block shifts the six drain-monitor fault bits out on SO. These bits are captured at the moment chip select falls.

A mode input picks the source of the gate enables. In serial mode every channel follows its bit in the latch. In hardware mode every channel follows its own parallel pin. For channels 0 and 1, and for channels 4 and 5, the parallel pin is ANDed with a PWM line that the pair shares. SCK, `cs_n` and SI are asynchronous to `clk` and pass through two-stage synchronizers. The serial clock must therefore run well below the system clock.

The frame sequencer has four states. ST_IDLE waits for chip select to fall. From ST_IDLE it goes to ST_SHIFT when SCK is low at that moment, or to ST_REJECT when SCK is high. ST_SHIFT counts rising edges and shifts data. When chip select rises, ST_SHIFT goes to ST_COMMIT if the count is 8 or 16, and to ST_IDLE otherwise. ST_REJECT returns to ST_IDLE when chip select rises. ST_COMMIT writes the latch for one cycle and returns to ST_IDLE.

Top module: `spi6_drive_ctrl`

## Requirements
- R1: After synchronous reset all six gate enables are 0 in serial mode and SO is 0.
- R2: In an 8-bit frame, SI is sampled on rising SCK edges with the most significant bit first. After chip select rises, gate_en[i] equals command bit i for i = 0..5 in serial mode (hw_sel = 0).
- R3: In a 16-bit frame only the last 8 bits received form the command. The first 8 bits have no effect on the latch.
- R4: A frame whose rising-edge count is neither 8 nor 16 (fewer than 8, between 9 and 15, or more than 16) leaves the latch unchanged.
- R5: A frame in which chip select falls while SCK is high is ignored entirely, and the latch keeps its value.
- R6: The latch changes only after chip select rises. During a frame the serial-mode gate enables keep their previous value.
- R7: When chip select falls, the word {2'b00, drain_fault[5:0]} is captured. SO presents bit 7 of that word first and advances one bit on each falling SCK edge. Bits after the eighth read 0.
- R8: In hardware mode (hw_sel = 1), gate_en[2] and gate_en[3] equal par_in[2] and par_in[3].
- R9: In hardware mode, gate_en[1:0] = par_in[1:0] & {2{pwm_lo}} and gate_en[5:4] = par_in[5:4] & {2{pwm_hi}}.
- R10: Switching modes does not modify the latch. On return to serial mode the gate enables again show the last committed command.
- R11: Command bits 7 and 6 of a frame have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out (fault status) |
| par_in | input | 6 | Per-channel parallel control pins |
| pwm_lo | input | 1 | PWM line for channels 0 and 1 |
| pwm_hi | input | 1 | PWM line for channels 4 and 5 |
| hw_sel | input | 1 | 1 = hardware pins drive outputs, 0 = serial latch |
| drain_fault | input | 6 | Drain-monitor fault bits |
| gate_en | output | 6 | Per-channel gate enables |

## Verification
Some rules are checked by assertions on every cycle:
- the latch moves only in the cycle after a commit;
- a commit happens only with a bit count of 8 or 16;
- a rejected frame never reaches commit;
- in hardware mode, the plain channels follow their pins and a low PWM line forces its pair off.

Other behaviour can only be shown by the bench scenarios: which bits of a long frame are kept, the order and timing of bits on SO, discarding of odd-length frames, and restoring the latch after a mode change.

// File: rtl/spi6_pkg.sv
package spi6_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_REJECT,
        ST_COMMIT
    } link_state_t;
endpackage

// File: rtl/spi6_sync.sv
module spi6_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/spi6_link.sv
module spi6_link
    import spi6_pkg::*;
#(
    parameter int CMD_W     = 8,
    parameter int LONG_BITS = 16,
    parameter int CHAN      = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sck,
    input  logic            cs_n,
    input  logic            si,
    input  logic [CHAN-1:0] status,
    output logic            so,
    output logic [CHAN-1:0] cmd,
    output logic            commit
);
    localparam int CNT_W = $clog2(LONG_BITS) + 2;
    localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(LONG_BITS);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    link_state_t state, state_nx;
    logic sck_q, cs_q;
    logic sck_rise, sck_fall, cs_fall, cs_rise;
    logic [CNT_W-1:0] bit_cnt;
    logic [CHAN-1:0]  rx;
    logic [CMD_W-1:0] tx;

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;
    assign cs_fall  = ~cs_n & cs_q;
    assign cs_rise  = cs_n & ~cs_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            state <= state_nx;
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) state_nx = sck ? ST_REJECT : ST_SHIFT;
            ST_SHIFT:  if (cs_rise)
                           state_nx = (bit_cnt == CNT_SHORT || bit_cnt == CNT_LONG)
                                      ? ST_COMMIT : ST_IDLE;
            ST_REJECT: if (cs_rise) state_nx = ST_IDLE;
            ST_COMMIT: state_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            rx      <= '0;
            tx      <= '0;
        end else if (state == ST_IDLE && cs_fall) begin
            bit_cnt <= '0;
            tx      <= {{(CMD_W-CHAN){1'b0}}, status};
        end else if (state == ST_SHIFT) begin
            if (sck_rise) begin
                rx      <= {rx[CHAN-2:0], si};
                bit_cnt <= (bit_cnt == CNT_MAX) ? bit_cnt : bit_cnt + 1'b1;
            end
            if (sck_fall) tx <= {tx[CMD_W-2:0], 1'b0};
        end
    end

    always_comb begin
        so     = tx[CMD_W-1];
        cmd    = rx;
        commit = (state == ST_COMMIT);
    end

    assert_commit_len_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COMMIT) |-> (bit_cnt == CNT_SHORT || bit_cnt == CNT_LONG));

    assert_reject_no_commit_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REJECT) |=> (state != ST_COMMIT));
endmodule

// File: rtl/spi6_chan_mux.sv
module spi6_chan_mux #(
    parameter int CHAN     = 6,
    parameter int PAIR_LEN = 2
) (
    input  logic [CHAN-1:0] latch,
    input  logic [CHAN-1:0] par_in,
    input  logic [1:0]      pwm,
    input  logic            hw_sel,
    output logic [CHAN-1:0] gate
);
    for (genvar i = 0; i < CHAN; i++) begin : g_chan
        if (i < PAIR_LEN) begin : g_low_pair
            assign gate[i] = hw_sel ? (par_in[i] & pwm[0]) : latch[i];
        end else if (i >= CHAN - PAIR_LEN) begin : g_high_pair
            assign gate[i] = hw_sel ? (par_in[i] & pwm[1]) : latch[i];
        end else begin : g_plain
            assign gate[i] = hw_sel ? par_in[i] : latch[i];
        end
    end
endmodule

// File: rtl/spi6_drive_ctrl.sv
module spi6_drive_ctrl #(
    parameter int CMD_W     = 8,
    parameter int LONG_BITS = 16,
    parameter int CHAN      = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sck,
    input  logic            cs_n,
    input  logic            si,
    output logic            so,
    input  logic [CHAN-1:0] par_in,
    input  logic            pwm_lo,
    input  logic            pwm_hi,
    input  logic            hw_sel,
    input  logic [CHAN-1:0] drain_fault,
    output logic [CHAN-1:0] gate_en
);
    logic [2:0]      pins_s;
    logic [CHAN-1:0] cmd;
    logic [CHAN-1:0] latch;
    logic            commit;

    spi6_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck, cs_n, si}),
        .q   (pins_s)
    );

    spi6_link #(.CMD_W(CMD_W), .LONG_BITS(LONG_BITS), .CHAN(CHAN)) u_link (
        .clk    (clk),
        .rst    (rst),
        .sck    (pins_s[2]),
        .cs_n   (pins_s[1]),
        .si     (pins_s[0]),
        .status (drain_fault),
        .so     (so),
        .cmd    (cmd),
        .commit (commit)
    );

    always_ff @(posedge clk) begin
        if (rst)         latch <= '0;
        else if (commit) latch <= cmd;
    end

    spi6_chan_mux #(.CHAN(CHAN), .PAIR_LEN(2)) u_mux (
        .latch  (latch),
        .par_in (par_in),
        .pwm    ({pwm_hi, pwm_lo}),
        .hw_sel (hw_sel),
        .gate   (gate_en)
    );

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(latch));

    assert_serial_view_R10: assert property (@(posedge clk) disable iff (rst)
        !hw_sel |-> (gate_en == latch));

    assert_plain_pins_R8: assert property (@(posedge clk) disable iff (rst)
        hw_sel |-> (gate_en[3:2] == par_in[3:2]));

    assert_pwm_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (hw_sel && !pwm_lo) |-> (gate_en[1:0] == 2'b00));
endmodule

// File: tb/spi6_drive_ctrl_test.sv
module spi6_drive_ctrl_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic       so;
    logic [5:0] par_in = '0;
    logic       pwm_lo = 1'b0, pwm_hi = 1'b0, hw_sel = 1'b0;
    logic [5:0] drain_fault = '0;
    logic [5:0] gate_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [5:0] exp_latch = '0;

    always #4 clk = ~clk;

    spi6_drive_ctrl uut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .so(so),
        .par_in(par_in), .pwm_lo(pwm_lo), .pwm_hi(pwm_hi), .hw_sel(hw_sel),
        .drain_fault(drain_fault), .gate_en(gate_en)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] hw_model(logic [5:0] p, logic lo, logic hi);
        return {p[5] & hi, p[4] & hi, p[3], p[2], p[1] & lo, p[0] & lo};
    endfunction

    task automatic run_frame(logic [31:0] bits, int n, bit hi_start,
                             logic [5:0] fault, string req);
        logic [7:0] stat;
        stat = {2'b00, fault};
        drain_fault = fault;
        if (hi_start) sck = 1'b1;
        tick(HALF);
        cs_n = 1'b0;
        tick(HALF);
        if (hi_start) begin
            sck = 1'b0;
            tick(HALF);
        end
        for (int k = 0; k < n; k++) begin
            si = bits[n-1-k];
            if (!hi_start) begin
                logic e;
                e = (k < 8) ? stat[7-k] : 1'b0;
                check(so == e, "R7", so, e);
            end
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
            tick(HALF);
        end
        check(gate_en == exp_latch, "R6", gate_en, exp_latch);
        cs_n = 1'b1;
        tick(HALF);
        if (!hi_start && (n == 8 || n == 16)) exp_latch = bits[5:0];
        check(gate_en == exp_latch, req, gate_en, exp_latch);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        tick(4);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check(gate_en == 6'h00, "R1", gate_en, 0);
        check(so == 1'b0, "R1", so, 0);

        run_frame(32'h2A, 8, 1'b0, 6'h2D, "R2");
        run_frame(32'hD5, 8, 1'b0, 6'h3F, "R11");
        check(gate_en == 6'h15, "R11", gate_en, 6'h15);
        run_frame(32'h3F09, 16, 1'b0, 6'h21, "R3");
        check(gate_en == 6'h09, "R3", gate_en, 6'h09);
        run_frame(32'h3F, 7, 1'b0, 6'h12, "R4");
        run_frame(32'h0FFF, 12, 1'b0, 6'h01, "R4");
        run_frame(32'hFFFFF, 20, 1'b0, 6'h00, "R4");
        check(gate_en == 6'h09, "R4", gate_en, 6'h09);
        run_frame(32'h36, 8, 1'b1, 6'h00, "R5");
        check(gate_en == 6'h09, "R5", gate_en, 6'h09);

        // R8 / R9 exhaustive hardware mode
        hw_sel = 1'b1;
        for (int v = 0; v < 256; v++) begin
            par_in = v[5:0];
            pwm_lo = v[6];
            pwm_hi = v[7];
            #2;
            check(gate_en[3:2] == par_in[3:2], "R8", gate_en, hw_model(par_in, pwm_lo, pwm_hi));
            check(gate_en == hw_model(par_in, pwm_lo, pwm_hi), "R9",
                  gate_en, hw_model(par_in, pwm_lo, pwm_hi));
        end
        hw_sel = 1'b0;
        #2;
        check(gate_en == exp_latch, "R10", gate_en, exp_latch);

        // constrained random frames
        for (int r = 0; r < 40; r++) begin
            int sel, n;
            logic [31:0] b;
            sel = int'($urandom % 5);
            n = (sel < 2) ? 8 : (sel < 4) ? 16 : 1 + int'($urandom % 20);
            b = $urandom;
            run_frame(b, n, 1'b0, 6'($urandom), (n == 8 || n == 16) ? "R2" : "R4");
            if ((r % 8) == 0) begin
                hw_sel = 1'b1;
                par_in = 6'($urandom);
                pwm_lo = 1'($urandom);
                pwm_hi = 1'($urandom);
                tick(2);
                check(gate_en == hw_model(par_in, pwm_lo, pwm_hi), "R9",
                      gate_en, hw_model(par_in, pwm_lo, pwm_hi));
                hw_sel = 1'b0;
                tick(1);
                check(gate_en == exp_latch, "R10", gate_en, exp_latch);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule